// File: doc/BRIEF.md
# Power-Fail Protected SRAM Port

This block is a clocked model of a byte-wide static memory behind three active-low strobes: chip enable, output enable and write enable. The strobes are sampled on the system clock. In each cycle the block decides whether the access is a read, a write or neither. It drives the read bus only when the read conditions hold.

A write window is open while chip enable and write enable are both low. The window therefore opens on the later of the two falling edges and closes on the earlier of the two rising edges. The byte is committed to the array when the window closes. After each write the port stays blind for a parameterised recovery gap. A power-fail input cancels every write, whatever the strobes are doing.

Protocol misuse sets a sticky error flag that only reset clears. Two cases count as misuse: a write window that opens inside the recovery gap, and an address that moves while a window is open. The full-size part uses `ADDR_W = 15`, which gives 32,768 bytes. The default is smaller to keep elaboration light.

Top module: `pfsram_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dataOutEn` is 0, `dataOut` is 0 and `protoErr` is 0.
- R2: Outputs are registered. One clock after `ceN`=0, `oeN`=0 and `weN`=1 are sampled outside a recovery gap, `dataOutEn` is 1 and `dataOut` holds the byte stored at the sampled `addr`.
- R3: If `oeN` or `ceN` is sampled high, then after that clock `dataOutEn` is 0 and `dataOut` is 0.
- R4: A write window is every sampled cycle with `ceN`=0 and `weN`=0. When the window closes, the array stores the `dataIn` sampled in the window's last cycle, at the `addr` sampled in its first cycle.
- R5: The window opens only when both strobes are low. A `weN` that falls before `ceN` captures nothing until `ceN` falls. The window closes as soon as either strobe rises.
- R6: A write enable sampled low while outputs are driven turns `dataOutEn` off at the next clock.
- R7: For `REC_CYC` clocks after a window closes, reads are not driven. A write window that opens in that gap stores nothing and sets `protoErr`.
- R8: If `pwrFail` is sampled high in any cycle of a window, or in the cycle where it closes, nothing is stored.
- R9: An `addr` sampled in a window that differs from the address held at its opening sets `protoErr`. The write still goes to the held address.
- R10: Once set, `protoErr` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| pwrFail | input | 1 | Supply out of tolerance; blocks writes |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Read data, 0 when not driven |
| dataOutEn | output | 1 | Read bus drive enable |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
The hardest case to reach is a write window that opens inside the recovery gap. The ports only show its effect through the error flag and through the stored byte that it must not overwrite. The stimulus closes a write and then lowers both strobes on the very next clock. It then waits out the gap and reads the same address back, expecting the earlier byte. Power fail raised in the middle of a window is reached the same way: the bench reads the target address back once the gap has ended.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr; // first cycle of a write window
    logic capData;   // any cycle inside a write window
    logic commit;    // window closed and write allowed
    logic readOk;    // read conditions hold this cycle
  } ctrlStb_t;
endpackage

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl
  import pfsram_pkg::*;
#(
  parameter int REC_CYC = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  input  logic     pwrFail,
  input  logic     addrMismatch,
  output ctrlStb_t stb,
  output logic     recBusy,
  output logic     protoErr
);
  localparam int CNT_W = $clog2(REC_CYC + 1);

  logic             wrNow, wrPrev, wrStart, wrEnd;
  logic             winOk;
  logic [CNT_W-1:0] recCnt;

  assign wrNow   = !ceN && !weN;
  assign wrStart = wrNow && !wrPrev;
  assign wrEnd   = !wrNow && wrPrev;
  assign recBusy = (recCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      winOk    <= 1'b0;
      recCnt   <= '0;
      protoErr <= 1'b0;
    end else begin
      wrPrev <= wrNow;
      if (wrStart)
        winOk <= !pwrFail && !recBusy;
      else if (wrNow && pwrFail)
        winOk <= 1'b0;
      if (wrEnd)
        recCnt <= CNT_W'(REC_CYC);
      else if (recBusy)
        recCnt <= recCnt - 1'b1;
      if ((wrStart && recBusy) || (wrNow && !wrStart && addrMismatch))
        protoErr <= 1'b1;
    end
  end

  always_comb begin
    stb.latchAddr = wrStart;
    stb.capData   = wrNow;
    stb.commit    = wrEnd && winOk && !pwrFail;
    stb.readOk    = !ceN && !oeN && weN && !recBusy;
  end
endmodule

// File: rtl/pfsram_dpath.sv
module pfsram_dpath
  import pfsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStb_t          stb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              addrMismatch
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldData;
  logic [DATA_W-1:0] rdData;

  assign addrMismatch = (addr != heldAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldData  <= '0;
      rdData    <= '0;
      dataOutEn <= 1'b0;
    end else begin
      if (stb.latchAddr) heldAddr <= addr;
      if (stb.capData)   heldData <= dataIn;
      dataOutEn <= stb.readOk;
      rdData    <= stb.readOk ? memArr[addr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit) memArr[heldAddr] <= heldData;
  end

  assign dataOut = dataOutEn ? rdData : '0;
endmodule

// File: rtl/pfsram_port.sv
module pfsram_port
  import pfsram_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              pwrFail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              protoErr
);
  ctrlStb_t stb;
  logic     recBusy;
  logic     addrMismatch;

  pfsram_ctrl #(.REC_CYC(REC_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pwrFail(pwrFail), .addrMismatch(addrMismatch),
    .stb(stb), .recBusy(recBusy), .protoErr(protoErr)
  );

  pfsram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .stb(stb),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .addrMismatch(addrMismatch)
  );
endmodule

// File: rtl/pfsram_port_chk.sv
module pfsram_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              pwrFail,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              protoErr,
  input logic              recBusy,
  input logic              commit
);
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> $past(!ceN && !oeN && weN)); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0); // R3
  AST_WE_DROPS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> !dataOutEn); // R6
  AST_NO_READ_IN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> $past(!recBusy)); // R7
  AST_PF_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> $past(!pwrFail)); // R8
  AST_COMMIT_AT_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (ceN || weN)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R10
endmodule

bind pfsram_port pfsram_port_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .pwrFail(pwrFail), .dataOut(dataOut), .dataOutEn(dataOutEn),
  .protoErr(protoErr), .recBusy(recBusy), .commit(stb.commit)
);

// File: tb/pfsram_port_test.sv
module pfsram_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, pwrFail = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOutEn, protoErr;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = !clk;

  pfsram_port uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pwrFail(pwrFail), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .protoErr(protoErr)
  );

  typedef struct packed {
    logic       ce, oe, we, pf;
    logic [10:0] a;
    logic [7:0] d;
    logic       expEn;
    logic [7:0] expD;
    logic       expErr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 0  R1 idle
    '{1'b0,1'b1,1'b0,1'b0, 11'd5, 8'hA5, 1'b0, 8'h00, 1'b0}, // 1  R4 open
    '{1'b0,1'b1,1'b0,1'b0, 11'd5, 8'h3C, 1'b0, 8'h00, 1'b0}, // 2  R4 last data
    '{1'b1,1'b1,1'b1,1'b0, 11'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // 3  R4 close
    '{1'b0,1'b0,1'b1,1'b0, 11'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // 4  R7 gap
    '{1'b0,1'b0,1'b1,1'b0, 11'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // 5  R7 gap
    '{1'b0,1'b0,1'b1,1'b0, 11'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // 6  R7 gap
    '{1'b0,1'b0,1'b1,1'b0, 11'd5, 8'h00, 1'b1, 8'h3C, 1'b0}, // 7  R2 R4 read
    '{1'b0,1'b1,1'b1,1'b0, 11'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // 8  R3 oe high
    '{1'b1,1'b1,1'b0,1'b0, 11'd9, 8'h11, 1'b0, 8'h00, 1'b0}, // 9  R5 we first
    '{1'b0,1'b1,1'b0,1'b0, 11'd9, 8'h22, 1'b0, 8'h00, 1'b0}, // 10 R5 ce falls
    '{1'b0,1'b1,1'b1,1'b0, 11'd9, 8'h00, 1'b0, 8'h00, 1'b0}, // 11 R5 we rises
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 12
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 13
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 14
    '{1'b0,1'b0,1'b1,1'b0, 11'd9, 8'h00, 1'b1, 8'h22, 1'b0}, // 15 R5 read
    '{1'b0,1'b0,1'b0,1'b0, 11'd9, 8'h77, 1'b0, 8'h00, 1'b0}, // 16 R6 we drops
    '{1'b0,1'b0,1'b0,1'b1, 11'd9, 8'h88, 1'b0, 8'h00, 1'b0}, // 17 R8 fail
    '{1'b1,1'b1,1'b1,1'b0, 11'd9, 8'h00, 1'b0, 8'h00, 1'b0}, // 18 R8 close
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 19
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 20
    '{1'b1,1'b1,1'b1,1'b0, 11'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // 21
    '{1'b0,1'b0,1'b1,1'b0, 11'd9, 8'h00, 1'b1, 8'h22, 1'b0}  // 22 R8 unchanged
  };

  task automatic apply(input logic c, input logic o, input logic w,
                       input logic p, input logic [10:0] a, input logic [7:0] d);
    ceN = c; oeN = o; weN = w; pwrFail = p; addr = a; dataIn = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
  endtask

  task automatic chk(input string req, input logic expEn,
                     input logic [7:0] expD, input logic expErr);
    checks++;
    if (dataOutEn !== expEn || dataOut !== expD || protoErr !== expErr) begin
      fails++;
      $display("FAIL %s: en/data/err got %b/%h/%b expected %b/%h/%b",
               req, dataOutEn, dataOut, protoErr, expEn, expD, expErr);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", 1'b0, 8'h00, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].ce, VECS[i].oe, VECS[i].we, VECS[i].pf, VECS[i].a, VECS[i].d);
      chk($sformatf("vector %0d (R1..R8)", i), VECS[i].expEn, VECS[i].expD, VECS[i].expErr);
    end

    // R7: write opening inside the recovery gap is dropped and flagged
    apply(1'b0, 1'b1, 1'b0, 1'b0, 11'd3, 8'h44);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 11'd3, 8'h00);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 11'd3, 8'h66);
    chk("R7 gap write flagged", 1'b0, 8'h00, 1'b1);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 11'd3, 8'h00);
    idle(4);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 11'd3, 8'h00);
    chk("R7 gap write not stored", 1'b1, 8'h44, 1'b1);

    // R10: flag holds
    idle(3);
    chk("R10 flag sticky", 1'b0, 8'h00, 1'b1);

    // R1: reset clears the flag
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears flag", 1'b0, 8'h00, 1'b0);
    rstN = 1'b1;
    idle(1);
    chk("R1 after reset", 1'b0, 8'h00, 1'b0);

    // R9: address moves in window; R5: ce rises first closes it
    apply(1'b0, 1'b1, 1'b0, 1'b0, 11'd7, 8'h12);
    chk("R9 no flag on open", 1'b0, 8'h00, 1'b0);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 11'd8, 8'h99);
    chk("R9 address change flagged", 1'b0, 8'h00, 1'b1);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 11'd8, 8'h00);
    idle(4);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 11'd7, 8'h00);
    chk("R9 R5 stored at held address", 1'b1, 8'h99, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 11'd7, 8'hEE);
    chk("R6 drive off on write enable", 1'b0, 8'h00, 1'b1);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 11'd7, 8'h00);
    idle(4);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 11'd7, 8'h00);
    chk("R8 fail at close blocks store", 1'b1, 8'h99, 1'b1);

    finishRun();
  end
endmodule